// File: doc/BRIEF.md
# Packet Interrupt Coalescer

This block sits next to a DMA channel and decides when packet completions interrupt the CPU. Each completion raises a flag and adds one to a pending-packet count. Two triggers can then raise an interrupt. The first fires when the pending count climbs to a programmed threshold. The second fires when a programmed number of timebase ticks pass with packets pending and no new completion arriving.

Software services packets one at a time. It reads the pending count through the register port and issues one decrement command per packet handled. The interrupt flags are cleared by writing ones to them. Each flag reaches the interrupt pin only when its enable bit is set. All register writes take effect on the next clock edge. Reads are combinational from the current register state.

Register addresses on `reg_addr_i`:
- 0: status, write-one-to-clear.
- 1: enable.
- 2: threshold, 8 bits.
- 3: wait bound, WAIT_W bits.
- 4: pending count on read. A write of any value is a decrement command.

Top module: `irq_coalescer`

## Requirements
- R1: A cycle with `pkt_done_i` high sets the packet flag, status bit 2, at the next clock edge.
- R2: Each `pkt_done_i` cycle adds one to the pending count, read at address 4.
- R3: A write to address 4 lowers the pending count by exactly one. At zero the write has no effect.
- R4: The 8-bit threshold at address 2 sets status bit 3 at the edge where a packet brings the pending count up to exactly the threshold value.
- R5: The wait bound at address 3 works as follows.
  - While the pending count is nonzero, the timer counts `tick_i` cycles.
  - A new packet restarts the count.
  - The tick that makes the count equal the bound sets status bit 4.
  - The timer fires once per quiet period, until the next packet or until the count drains to zero.
- R6: Status bits 2 to 4 are cleared by writing one to them. Writing zero leaves them unchanged. A set in the same cycle wins over a clear. All other status bits read zero.
- R7: A threshold of zero disables the bit 3 trigger. A wait bound of zero disables the bit 4 trigger.
- R8: The enable register at address 1 uses the status bit positions, with only bits 2 to 4 stored. `irq_o` is high exactly when some status bit is set together with its enable bit.
- R9: The pending count saturates at 2^CNT_W-1. A packet and a decrement in the same cycle leave the count unchanged.
- R10: After reset, all registers read zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_done_i | input | 1 | One-cycle strobe per completed packet |
| tick_i | input | 1 | Timebase pulse for the wait timer |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | REG_W | Write data; REG_W = max(8, CNT_W, WAIT_W) |
| reg_rdata_o | output | REG_W | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W=4 and WAIT_W=6, which gives an 8-bit register port. This makes the pending count saturate after 15 packets. Counter saturation, and a packet arriving in the same cycle as a decrement at the limit, can therefore be tested in a few dozen cycles.

A wait bound of four ticks keeps the timer paths short. These paths are expiry, the hold after firing, restart by a new packet, and staying idle with nothing pending.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int THR_W  = 8;
  localparam int IXR_W  = 8;
  localparam int FLAG_N = 3;   // implemented flags: packet, threshold, wait
  localparam int FLAG_LO = 2;  // lowest implemented status bit

  localparam logic [2:0] ADDR_STAT = 3'd0;
  localparam logic [2:0] ADDR_EN   = 3'd1;
  localparam logic [2:0] ADDR_THR  = 3'd2;
  localparam logic [2:0] ADDR_WAIT = 3'd3;
  localparam logic [2:0] ADDR_PEND = 3'd4;

  typedef struct packed {
    logic wait_hit;
    logic thr_hit;
    logic pkt;
  } evt_t;

  function automatic int reg_width(input int cnt_w, input int wait_w);
    int w;
    w = IXR_W;
    if (THR_W > w) w = THR_W;
    if (cnt_w > w) w = cnt_w;
    if (wait_w > w) w = wait_w;
    return w;
  endfunction
endpackage

// File: rtl/coal_pend_cnt.sv
module coal_pend_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             grew_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    nxt_o  = cnt_q;
    grew_o = 1'b0;
    if (inc_i && !dec_i) begin
      if (cnt_q != CNT_MAX) begin
        nxt_o  = cnt_q + 1'b1;
        grew_o = 1'b1;
      end
    end else if (dec_i && !inc_i) begin
      if (cnt_q != '0) nxt_o = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/coal_wait_timer.sv
module coal_wait_timer #(
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic              active_i,
  input  logic [WAIT_W-1:0] bound_i,
  output logic              expire_o
);
  logic [WAIT_W-1:0] tmr_q;
  logic              fired_q;
  logic [WAIT_W:0]   tmr_inc;
  logic              armed;

  assign tmr_inc  = {1'b0, tmr_q} + (WAIT_W+1)'(1);
  assign armed    = active_i && !restart_i && !fired_q && (bound_i != '0);
  assign expire_o = armed && tick_i && (tmr_inc >= {1'b0, bound_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      fired_q <= 1'b0;
    end else if (restart_i || !active_i) begin
      tmr_q   <= '0;
      fired_q <= 1'b0;
    end else if (expire_o) begin
      tmr_q   <= '0;
      fired_q <= 1'b1;
    end else if (armed && tick_i) begin
      tmr_q   <= tmr_inc[WAIT_W-1:0];
    end
  end
endmodule

// File: rtl/coal_csr.sv
module coal_csr
  import coal_pkg::*;
#(
  parameter int WAIT_W = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  evt_t              set_i,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [FLAG_N-1:0] stat_o,
  output logic [FLAG_N-1:0] en_o,
  output logic [THR_W-1:0]  thr_o,
  output logic [WAIT_W-1:0] bound_o
);
  logic [FLAG_N-1:0] stat_q, stat_n, en_q, wr_flags;
  logic [THR_W-1:0]  thr_q;
  logic [WAIT_W-1:0] bound_q;

  assign wr_flags = wdata_i[FLAG_LO +: FLAG_N];

  always_comb begin
    stat_n = stat_q;
    if (wr_i && addr_i == ADDR_STAT) stat_n = stat_q & ~wr_flags;
    stat_n = stat_n | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      bound_q <= '0;
    end else begin
      stat_q <= stat_n;
      if (wr_i) begin
        case (addr_i)
          ADDR_EN:   en_q    <= wr_flags;
          ADDR_THR:  thr_q   <= wdata_i[THR_W-1:0];
          ADDR_WAIT: bound_q <= wdata_i[WAIT_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  assign stat_o  = stat_q;
  assign en_o    = en_q;
  assign thr_o   = thr_q;
  assign bound_o = bound_q;
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
  import coal_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int WAIT_W = 16,
  localparam int REG_W = reg_width(CNT_W, WAIT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_done_i,
  input  logic             tick_i,
  input  logic             reg_wr_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic              dec_cmd;
  logic [CNT_W-1:0]  pend_cnt, pend_nxt;
  logic              pend_grew;
  logic              thr_eq;
  logic              wait_exp;
  evt_t              evt;
  logic [FLAG_N-1:0] stat_q, en_q;
  logic [THR_W-1:0]  thr_q;
  logic [WAIT_W-1:0] bound_q;

  assign dec_cmd = reg_wr_i && (reg_addr_i == ADDR_PEND);

  coal_pend_cnt #(.CNT_W(CNT_W)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (pkt_done_i),
    .dec_i  (dec_cmd),
    .cnt_o  (pend_cnt),
    .nxt_o  (pend_nxt),
    .grew_o (pend_grew)
  );

  coal_wait_timer #(.WAIT_W(WAIT_W)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .restart_i (pkt_done_i),
    .active_i  (pend_cnt != '0),
    .bound_i   (bound_q),
    .expire_o  (wait_exp)
  );

  generate
    if (CNT_W >= THR_W) begin : g_cmp_cnt
      assign thr_eq = (pend_nxt == CMP_W'(thr_q));
    end else begin : g_cmp_thr
      assign thr_eq = (CMP_W'(pend_nxt) == thr_q);
    end
  endgenerate

  assign evt.pkt      = pkt_done_i;
  assign evt.thr_hit  = pend_grew && (thr_q != '0) && thr_eq;
  assign evt.wait_hit = wait_exp;

  coal_csr #(.WAIT_W(WAIT_W), .REG_W(REG_W)) u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (evt),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .stat_o  (stat_q),
    .en_o    (en_q),
    .thr_o   (thr_q),
    .bound_o (bound_q)
  );

  always_comb begin
    case (reg_addr_i)
      ADDR_STAT: reg_rdata_o = REG_W'({stat_q, {FLAG_LO{1'b0}}});
      ADDR_EN:   reg_rdata_o = REG_W'({en_q, {FLAG_LO{1'b0}}});
      ADDR_THR:  reg_rdata_o = REG_W'(thr_q);
      ADDR_WAIT: reg_rdata_o = REG_W'(bound_q);
      ADDR_PEND: reg_rdata_o = REG_W'(pend_cnt);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(stat_q & en_q);
endmodule

// File: rtl/irq_coalescer_chk.sv
module irq_coalescer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_i,
  input logic             dec_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             st_pkt_i,
  input logic             st_thr_i,
  input logic             thr_zero_i,
  input logic             en_any_i,
  input logic             irq_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_PKT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_i |=> st_pkt_i); // R1
  AST_PEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_i && !dec_i && cnt_i != CNT_MAX) |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1)); // R2
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !pkt_i && cnt_i != '0) |=> cnt_i == CNT_W'($past(cnt_i) - 1'b1)); // R3
  AST_DEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !pkt_i && cnt_i == '0) |=> cnt_i == '0); // R3
  AST_THR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_zero_i && !st_thr_i) |=> !st_thr_i); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |-> en_any_i); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i == CNT_MAX && pkt_i && !dec_i) |=> cnt_i == CNT_MAX); // R9
  AST_INC_DEC_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_i && dec_i) |=> $stable(cnt_i)); // R9
endmodule

bind irq_coalescer irq_coalescer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pkt_i      (pkt_done_i),
  .dec_i      (dec_cmd),
  .cnt_i      (pend_cnt),
  .st_pkt_i   (stat_q[0]),
  .st_thr_i   (stat_q[1]),
  .thr_zero_i (thr_q == '0),
  .en_any_i   (|en_q),
  .irq_i      (irq_o)
);

// File: tb/irq_coalescer_test.sv
module irq_coalescer_test;
  localparam int PERIOD = 10;
  localparam int CNT_W  = 4;
  localparam int WAIT_W = 6;
  localparam int RW     = 8;

  localparam logic [2:0] A_STAT = 3'd0, A_EN = 3'd1, A_THR = 3'd2,
                         A_WAIT = 3'd3, A_PEND = 3'd4;

  typedef struct {
    bit          is_irq;
    logic [RW-1:0] exp;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pkt = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [2:0]    addr = '0;
  logic [RW-1:0] wdata = '0;
  logic [RW-1:0] rdata;
  logic          irq;

  int   vecs = 0;
  int   errs = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #(PERIOD/2) clk = ~clk;

  irq_coalescer #(.CNT_W(CNT_W), .WAIT_W(WAIT_W)) uut (
    .clk(clk), .rst_n(rst_n), .pkt_done_i(pkt), .tick_i(tick),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // driver: inputs change 1 time unit after the rising edge
  task automatic step(input logic p, input logic t, input logic w,
                      input logic [2:0] a, input logic [RW-1:0] d);
    @(posedge clk); #1;
    pkt = p; tick = t; wr = w; addr = a; wdata = d;
  endtask

  task automatic idle();            step(0, 0, 0, A_STAT, '0); endtask
  task automatic put_pkt();         step(1, 0, 0, A_STAT, '0); endtask
  task automatic put_tick();        step(0, 1, 0, A_STAT, '0); endtask
  task automatic put_dec();         step(0, 0, 1, A_PEND, '0); endtask
  task automatic wreg(input logic [2:0] a, input logic [RW-1:0] d);
    step(0, 0, 1, a, d);
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [RW-1:0] e, input string tag);
    exp_t it;
    step(0, 0, 0, a, '0);
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expect_irq(input logic e, input string tag);
    exp_t it;
    step(0, 0, 0, A_STAT, '0);
    it.is_irq = 1'b1; it.exp = RW'(e); it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t it;
        logic [RW-1:0] got;
        it  = sb.pop_front();
        got = it.is_irq ? RW'(irq) : rdata;
        vecs++;
        if (got !== it.exp) begin
          errs++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    expect_rd(A_STAT, 8'h00, "R10 status");
    expect_rd(A_PEND, 8'h00, "R10 pending");
    expect_rd(A_EN,   8'h00, "R10 enable");
    expect_rd(A_THR,  8'h00, "R10 threshold");
    expect_rd(A_WAIT, 8'h00, "R10 wait bound");
    expect_irq(1'b0, "R10 irq");

    // R1 / R2
    put_pkt();
    expect_rd(A_STAT, 8'h04, "R1 packet flag");
    expect_rd(A_PEND, 8'h01, "R2 count one");
    // R6 write zero keeps, write one clears
    wreg(A_STAT, 8'h00);
    expect_rd(A_STAT, 8'h04, "R6 write zero");
    wreg(A_STAT, 8'h04);
    expect_rd(A_STAT, 8'h00, "R6 write one");
    put_pkt();
    expect_rd(A_PEND, 8'h02, "R2 count two");
    // R3 decrement and floor
    put_dec();
    expect_rd(A_PEND, 8'h01, "R3 decrement");
    put_dec();
    put_dec();
    expect_rd(A_PEND, 8'h00, "R3 floor at zero");
    wreg(A_STAT, 8'hff);
    expect_rd(A_STAT, 8'h00, "R6 unused bits read zero");

    // R4 threshold
    wreg(A_THR, 8'd3);
    expect_rd(A_THR, 8'd3, "R4 threshold readback");
    put_pkt(); put_pkt();
    expect_rd(A_STAT, 8'h04, "R4 below threshold");
    put_pkt();
    expect_rd(A_STAT, 8'h0c, "R4 threshold reached");
    put_dec(); put_dec(); put_dec();
    wreg(A_STAT, 8'hff);
    // R7 threshold zero
    wreg(A_THR, 8'd0);
    put_pkt(); put_pkt(); put_pkt(); put_pkt();
    expect_rd(A_STAT, 8'h04, "R7 threshold disabled");
    put_dec(); put_dec(); put_dec(); put_dec();
    wreg(A_STAT, 8'hff);
    expect_rd(A_PEND, 8'h00, "R3 drained");

    // R5 wait bound
    wreg(A_WAIT, 8'd4);
    for (int i = 0; i < 6; i++) put_tick();
    expect_rd(A_STAT, 8'h00, "R5 idle with nothing pending");
    put_pkt();
    for (int i = 0; i < 3; i++) put_tick();
    expect_rd(A_STAT, 8'h04, "R5 before bound");
    put_tick();
    expect_rd(A_STAT, 8'h14, "R5 bound reached");
    wreg(A_STAT, 8'h14);
    for (int i = 0; i < 6; i++) put_tick();
    expect_rd(A_STAT, 8'h00, "R5 fires once");
    put_pkt();
    wreg(A_STAT, 8'h04);
    put_tick(); put_tick();
    put_pkt();
    wreg(A_STAT, 8'h04);
    for (int i = 0; i < 3; i++) put_tick();
    expect_rd(A_STAT, 8'h00, "R5 restart by packet");
    put_tick();
    expect_rd(A_STAT, 8'h10, "R5 fires after restart");
    // R7 wait bound zero
    wreg(A_WAIT, 8'd0);
    wreg(A_STAT, 8'hff);
    for (int i = 0; i < 10; i++) put_tick();
    expect_rd(A_STAT, 8'h00, "R7 wait disabled");
    put_dec(); put_dec(); put_dec();
    expect_rd(A_PEND, 8'h00, "R3 drained again");

    // R8 enables
    wreg(A_EN, 8'h04);
    expect_irq(1'b0, "R8 enabled but no flag");
    put_pkt();
    expect_irq(1'b1, "R8 enabled flag");
    expect_rd(A_EN, 8'h04, "R8 enable readback");
    wreg(A_EN, 8'h08);
    expect_irq(1'b0, "R8 flag not enabled");
    wreg(A_EN, 8'hff);
    expect_rd(A_EN, 8'h1c, "R8 stored enable bits");
    expect_irq(1'b1, "R8 all enabled");
    wreg(A_STAT, 8'hff);
    expect_irq(1'b0, "R8 flags cleared");
    wreg(A_EN, 8'h00);
    put_dec();

    // R6 set wins over clear
    step(1, 0, 1, A_STAT, 8'h04);
    expect_rd(A_STAT, 8'h04, "R6 set beats clear");

    // R9 saturation and cancel
    for (int i = 0; i < 20; i++) put_pkt();
    expect_rd(A_PEND, 8'h0f, "R9 saturated");
    step(1, 0, 1, A_PEND, '0);
    expect_rd(A_PEND, 8'h0f, "R9 cancel at limit");
    put_dec();
    expect_rd(A_PEND, 8'h0e, "R9 below limit");
    step(1, 0, 1, A_PEND, '0);
    expect_rd(A_PEND, 8'h0e, "R9 cancel");

    idle(); idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule